// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small processor core in a private four-slot stack. The core pulses a call strobe to save a program-counter value and a return strobe to take one back. The most recently saved value is always presented on a read port, so the core can load it in the same cycle that it issues the return. Neither the slots nor the pointer are reachable from the data or program address spaces, and no port reads or writes them directly.

The block also gates interrupt entry. A one-cycle request pulse is held in an internal flag. The block grants the acknowledge only while a slot is free and the core is not issuing a call or a return in that cycle. A granted acknowledge saves the presented program-counter value in the same way a call does. On a full stack the acknowledge is withheld until a return frees a slot. A call on a full stack is still accepted, and it overwrites the oldest entry.

Call, return and the interrupt request are plain control strobes without back-pressure. The stack accepts every strobe in the cycle it is asserted.

Top module: `ras_ctrl`

## Requirements
- R1: After reset the stack holds no entries, `full_o` and `irq_ack_o` are low, and `ret_pc_o` reads 0, because all slots are cleared.
- R2: A call (`push_i` high) stores `push_pc_i`. From the next cycle `ret_pc_o` shows that value. Returns give back the stored values in last-in, first-out order.
- R3: `full_o` is high exactly when four entries are occupied.
- R4: A call on a full stack overwrites the oldest entry. The occupancy stays at four and the four most recent values remain, still returned newest first.
- R5: A return on an empty stack leaves the occupancy at zero. The write position still steps back by one, modulo 4. `ret_pc_o` always shows the slot just below the write position, taken modulo 4.
- R6: When `push_i` and `pop_i` are high in the same cycle, the call is performed and the return is ignored.
- R7: An `irq_req_i` pulse sets a pending flag. While the flag is set, `irq_ack_o` is high in any cycle where the stack is not full and neither `push_i` nor `pop_i` is high. An acknowledge stores `push_pc_i` exactly as a call does.
- R8: While the stack is full, a pending request gets no acknowledge. It is acknowledged in the first free cycle after a return has lowered the occupancy.
- R9: Each acknowledge clears the pending flag, so one request gives one acknowledge cycle, unless a new request arrives in that same cycle.
- R10: A cycle with `push_i` or `pop_i` high never carries `irq_ack_o`. The request stays pending for a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Call strobe: save `push_pc_i` |
| pop_i | input | 1 | Return strobe: discard the top entry |
| push_pc_i | input | PC_W | Program-counter value to save on a call or acknowledge |
| ret_pc_o | output | PC_W | Top entry, the value a return restores |
| full_o | output | 1 | Four entries occupied |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_ack_o | output | 1 | Interrupt acknowledge, which also saves `push_pc_i` |

## Verification
`ret_pc_o`, `full_o` and `irq_ack_o` are decoded from registered state and from the strobes of the current cycle, so they are valid within the cycle in which they are used. Storage, occupancy and the pending flag change at the next rising edge. A request pulse can therefore produce an acknowledge one cycle later at the earliest. The bench drives each cycle's strobes just after a falling edge and samples all three outputs 1 ns later, before the rising edge. It advances its own arithmetic model of the slots, the write position, the occupancy and the pending flag only at that rising edge. Every comparison therefore sees exactly the state that results from the previous cycle's strobes.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2
  } ras_op_e;
endpackage

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req_i,
  input  logic full_i,
  input  logic push_i,
  input  logic pop_i,
  output logic ack_o,
  output logic flag_o
);
  logic flag_q;

  // grant only into a free slot and only in a cycle the core leaves alone
  assign ack_o  = flag_q & ~full_i & ~push_i & ~pop_i;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= irq_req_i | (flag_q & ~ack_o);
  end
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_op_e          op_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] OCC_MAX = CNT_W'(DEPTH);

  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      occ_q <= '0;
    end else begin
      case (op_i)
        RAS_PUSH: begin
          idx_q <= idx_q + 1'b1;
          if (occ_q != OCC_MAX) occ_q <= occ_q + 1'b1;
        end
        RAS_POP: begin
          idx_q <= idx_q - 1'b1;
          if (occ_q != '0) occ_q <= occ_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign wr_idx_o = idx_q;
  assign rd_idx_o = idx_q - 1'b1;
  assign occ_o    = occ_q;
  assign full_o   = (occ_q == OCC_MAX);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int PC_W  = 11,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_data_o
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))    slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            full_o,
  input  logic            irq_req_i,
  output logic            irq_ack_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ras_op_e          op_w;
  logic [IDX_W-1:0] wr_idx_w;
  logic [IDX_W-1:0] rd_idx_w;
  logic [CNT_W-1:0] occ_w;
  logic             irq_flag_w;
  logic             full_w;
  logic             ack_w;

  ras_irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_i (irq_req_i),
    .full_i    (full_w),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .ack_o     (ack_w),
    .flag_o    (irq_flag_w)
  );

  // a call or a granted acknowledge saves the PC; a call beats a return
  always_comb begin
    if (push_i || ack_w) op_w = RAS_PUSH;
    else if (pop_i)      op_w = RAS_POP;
    else                 op_w = RAS_IDLE;
  end

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_w),
    .wr_idx_o (wr_idx_w),
    .rd_idx_o (rd_idx_w),
    .occ_o    (occ_w),
    .full_o   (full_w)
  );

  ras_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (op_w == RAS_PUSH),
    .wr_idx_i  (wr_idx_w),
    .wr_data_i (push_pc_i),
    .rd_idx_i  (rd_idx_w),
    .rd_data_o (ret_pc_o)
  );

  assign full_o    = full_w;
  assign irq_ack_o = ack_w;
endmodule

// File: rtl/ras_ctrl_chk.sv
module ras_ctrl_chk #(
  parameter int PC_W  = 11,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic [PC_W-1:0]  push_pc_i,
  input logic [PC_W-1:0]  ret_pc_o,
  input logic             full_o,
  input logic             irq_ack_o,
  input logic [CNT_W-1:0] occ,
  input logic             flag
);
  assert_saved_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i || irq_ack_o) |=> (ret_pc_o == $past(push_pc_i)));

  assert_full_stays_on_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> full_o);

  assert_pop_frees_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && full_o) |=> !full_o);

  assert_empty_pop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && occ == '0) |=> (occ == '0));

  assert_push_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full_o) |=> (occ == $past(occ) + 1'b1));

  assert_ack_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> flag);

  assert_no_ack_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);

  assert_no_ack_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i || pop_i) |-> !irq_ack_o);
endmodule

bind ras_ctrl ras_ctrl_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .push_pc_i (push_pc_i),
  .ret_pc_o  (ret_pc_o),
  .full_o    (full_o),
  .irq_ack_o (irq_ack_o),
  .occ       (occ_w),
  .flag      (irq_flag_w)
);

// File: tb/tb_ras_ctrl.sv
`timescale 1ns/1ps
module tb_ras_ctrl;
  localparam int PC_W  = 11;
  localparam int DEPTH = 4;
  localparam int IDX_W = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            push_i, pop_i, irq_req_i;
  logic [PC_W-1:0] push_pc_i;
  logic [PC_W-1:0] ret_pc_o;
  logic            full_o, irq_ack_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench model
  logic [PC_W-1:0]  mdl [DEPTH];
  logic [IDX_W-1:0] widx;
  int               cnt;
  logic             pend;

  always #2.5 clk = ~clk;

  ras_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_pc_i(push_pc_i), .ret_pc_o(ret_pc_o), .full_o(full_o),
    .irq_req_i(irq_req_i), .irq_ack_o(irq_ack_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; irq_req_i = 1'b0; push_pc_i = '0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    widx = '0; cnt = 0; pend = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check({31'd0, full_o},    32'd0, "R1 full after reset");
    check({31'd0, irq_ack_o}, 32'd0, "R1 ack after reset");
    check({21'd0, ret_pc_o},  32'd0, "R1 top after reset");
    @(negedge clk);
  endtask

  // one cycle: drive at the falling edge, sample 1 ns later, update model at the rising edge
  task automatic step(input logic ps, input logic pp, input logic irq, input logic [PC_W-1:0] pc);
    logic exp_ack;
    push_i = ps; pop_i = pp; irq_req_i = irq; push_pc_i = pc;
    #1;
    exp_ack = pend && (cnt < DEPTH) && !ps && !pp;
    check({31'd0, irq_ack_o}, {31'd0, exp_ack}, "R7/R8/R9/R10 acknowledge");
    check({31'd0, full_o}, {31'd0, (cnt == DEPTH)}, "R3 full flag");
    check({21'd0, ret_pc_o}, {21'd0, mdl[widx - 1'b1]}, "R2/R4/R5/R6 top value");
    @(posedge clk);
    if (ps || exp_ack) begin
      mdl[widx] = pc;
      widx = widx + 1'b1;
      if (cnt < DEPTH) cnt++;
    end else if (pp) begin
      widx = widx - 1'b1;
      if (cnt > 0) cnt--;
    end
    pend = irq || (pend && !exp_ack);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R2 R4 R5: every push depth 0..6 followed by every pop depth 0..6
    for (int np = 0; np <= 6; np++) begin
      for (int nq = 0; nq <= 6; nq++) begin
        do_reset();
        for (int k = 0; k < np; k++) step(1'b1, 1'b0, 1'b0, PC_W'(np * 64 + nq * 8 + k + 1));
        for (int k = 0; k < nq; k++) step(1'b0, 1'b1, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, '0);
      end
    end

    // R6: simultaneous call and return across all fill levels
    do_reset();
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0, PC_W'(k + 11'h200));
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, '0);

    // R7 R9: request then idle, one acknowledge that saves the presented PC
    do_reset();
    step(1'b0, 1'b0, 1'b1, '0);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, PC_W'(11'h3A0 + k));
    step(1'b0, 1'b1, 1'b0, '0);

    // R8: full stack holds off, a return releases
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, PC_W'(11'h100 + k));
    step(1'b0, 1'b0, 1'b1, '0);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 11'h7FF);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, 11'h555);
    step(1'b0, 1'b0, 1'b0, 11'h0AA);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, '0);

    // R10: pending request held across call and return cycles
    do_reset();
    step(1'b0, 1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 1'b0, 11'h0F0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, 11'h0F1);
    step(1'b0, 1'b0, 1'b0, 11'h0F2);
    step(1'b0, 1'b0, 1'b0, 11'h0F3);

    // R9: back-to-back requests, one arriving in the acknowledge cycle
    do_reset();
    step(1'b0, 1'b0, 1'b1, '0);
    step(1'b0, 1'b0, 1'b1, 11'h010);
    step(1'b0, 1'b0, 1'b0, 11'h011);
    step(1'b0, 1'b0, 1'b0, 11'h012);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule